// File: doc/BRIEF.md
# Warp Lane-Mask Divergence Controller

This block decides which lanes of a SIMD warp are live while the warp runs through data-dependent if/else code. It also decides which instruction address the warp issues next. Branches are never predicted. When a branch arrives with its per-lane condition already resolved, the block compares the condition against the current lane mask. If the lanes disagree, it records the enclosing state on a small hardware stack. The warp then issues the then-block using only the condition-true lanes, followed by the else-block using only the condition-false lanes. At the join point the enclosing mask comes back. Nested conditionals stack further entries, so the paths are issued one after another.

A fetch stage drives the decode inputs for the instruction at `pc_o`, and `step_i` says that this instruction is issued in the current cycle. The program follows a fixed layout:

- A branch carries its else-block address in `target_i` and its join address in `reconv_i`.
- The then-block starts right after the branch and ends with a jump to the join address.
- The else-block runs up to the join address.

The per-lane writeback enable `wb_en_o` lets only lanes on the path being issued commit results. Nested conditionals must use distinct join addresses.

Top module: `warp_mask_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `pc_o` = RESET_PC (0), `mask_o` = all ones and `overflow_o` = 0, and empties the stack.
- R2: An issued ordinary instruction (`step_i`=1, `is_branch_i`=0, `is_jump_i`=0) advances `pc_o` by one on the next edge. During that cycle `wb_en_o` equals `mask_o`, where bit i is lane i. For an issued branch or jump, `wb_en_o` is zero.
- R3: An issued branch whose condition splits the active lanes (both mask&cond and mask&~cond are nonzero) pushes an entry, sets `mask_o` to mask&cond and moves to pc+1.
- R4: An issued jump whose target equals the top entry's join address, while that entry is still on its then-path, moves to the entry's else address. It also sets `mask_o` to the saved mask ANDed with the inverted condition.
- R5: During an else-path, when the next issue address equals the top entry's join address, the entry is popped and `mask_o` returns to the mask saved at the branch.
- R6: A branch whose condition is true on every active lane pushes nothing, keeps the mask and moves to pc+1. The then-block's closing jump then behaves as an ordinary jump to its target.
- R7: A branch whose condition is false on every active lane pushes nothing, keeps the mask and moves straight to `target_i`.
- R8: Inner conditionals nested in an outer path pop before the outer entry. Each pop restores the mask of its own level, so the outer path continues with its own mask.
- R9: A splitting branch that arrives with DEPTH entries already stacked sets `overflow_o`, which stays set until reset. That branch pushes nothing, keeps the mask and moves to pc+1.
- R10: When the else address equals the join address (empty else-block), the then-path's closing jump pops the entry directly and restores the saved mask at the join address.
- R11: When `step_i` is 0, `pc_o`, `mask_o` and the stack hold, and `wb_en_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction at `pc_o` is issued this cycle |
| is_branch_i | input | 1 | Issued instruction is a conditional branch |
| is_jump_i | input | 1 | Issued instruction is an unconditional jump |
| cond_i | input | LANES | Resolved per-lane branch condition |
| target_i | input | PCW | Else-block address (branch) or destination (jump) |
| reconv_i | input | PCW | Join address of a branch |
| pc_o | output | PCW | Address of the next instruction to issue |
| mask_o | output | LANES | Current active-lane mask |
| wb_en_o | output | LANES | Per-lane writeback enable for the issued instruction |
| overflow_o | output | 1 | Sticky flag: a split branch found the stack full |

## Verification
The bench runs one 8-lane program through the following cases:
- A two-level nested split.
- A uniform-true branch inside an else-path, whose closing jump must not be taken for the outer entry's turnaround.
- A uniform-false branch.
- A split with an empty else-block.
- A triple nesting against a two-entry stack.

A design that matched jumps without checking the join address would send the uniform branch's jump into the outer else-path. One that popped in the wrong order would bring back the inner mask at the outer join. Missing the empty-else case would issue a zero-length path with the wrong lanes or leak an entry. Issue is also stalled at irregular cycles, so a design that advanced or wrote back without `step_i` would show wrong addresses and stray enables.

// File: rtl/wms_pkg.sv
package wms_pkg;

    typedef enum logic {
        PH_THEN = 1'b0,
        PH_ELSE = 1'b1
    } path_phase_e;

    typedef enum logic [1:0] {
        STK_IDLE   = 2'd0,
        STK_PUSH   = 2'd1,
        STK_POP    = 2'd2,
        STK_TOELSE = 2'd3
    } stack_op_e;

    function automatic logic lanes_split(input logic [63:0] taken, input logic [63:0] fallen);
        return (taken != '0) && (fallen != '0);
    endfunction

endpackage

// File: rtl/wms_stack.sv
module wms_stack
    import wms_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PCW   = 8,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  stack_op_e         op_i,
    input  logic [PCW-1:0]    push_reconv_i,
    input  logic [PCW-1:0]    push_else_i,
    input  logic [LANES-1:0]  push_saved_i,
    input  logic [LANES-1:0]  push_emask_i,
    output logic [PCW-1:0]    top_reconv_o,
    output logic [PCW-1:0]    top_else_o,
    output logic [LANES-1:0]  top_saved_o,
    output logic [LANES-1:0]  top_emask_o,
    output path_phase_e       top_phase_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int SPW  = $clog2(DEPTH + 1);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SPW-1:0]   sp_q;
    logic [IDXW-1:0]  top_idx;
    logic [IDXW-1:0]  wr_idx;
    logic [DEPTH-1:0] wr_sel;
    logic [DEPTH-1:0] else_sel;

    logic [PCW-1:0]   reconv_q [DEPTH];
    logic [PCW-1:0]   else_q   [DEPTH];
    logic [LANES-1:0] saved_q  [DEPTH];
    logic [LANES-1:0] emask_q  [DEPTH];
    path_phase_e      phase_q  [DEPTH];

    assign top_idx = IDXW'(sp_q - 1'b1);
    assign wr_idx  = IDXW'(sp_q);
    assign empty_o = (sp_q == '0);
    assign full_o  = (sp_q == SPW'(DEPTH));

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            assign wr_sel[e]   = (op_i == STK_PUSH)   && (wr_idx  == IDXW'(e));
            assign else_sel[e] = (op_i == STK_TOELSE) && (top_idx == IDXW'(e));

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q[e]  <= PH_THEN;
                    reconv_q[e] <= '0;
                    else_q[e]   <= '0;
                    saved_q[e]  <= '0;
                    emask_q[e]  <= '0;
                end else if (wr_sel[e]) begin
                    phase_q[e]  <= PH_THEN;
                    reconv_q[e] <= push_reconv_i;
                    else_q[e]   <= push_else_i;
                    saved_q[e]  <= push_saved_i;
                    emask_q[e]  <= push_emask_i;
                end else if (else_sel[e]) begin
                    phase_q[e]  <= PH_ELSE;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else begin
            case (op_i)
                STK_PUSH: sp_q <= sp_q + 1'b1;
                STK_POP:  sp_q <= sp_q - 1'b1;
                default:  sp_q <= sp_q;
            endcase
        end
    end

    assign top_reconv_o = reconv_q[top_idx];
    assign top_else_o   = else_q[top_idx];
    assign top_saved_o  = saved_q[top_idx];
    assign top_emask_o  = emask_q[top_idx];
    assign top_phase_o  = phase_q[top_idx];

    // R9: the controller never pushes onto a full stack
    p_push_not_full_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH) |-> !full_o);

    // R5: a pop or phase change only happens with an entry present
    p_pop_not_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_POP || op_i == STK_TOELSE) |-> !empty_o);

    // R8: depth never exceeds the parameter
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
        sp_q <= SPW'(DEPTH));

endmodule

// File: rtl/wms_ctrl.sv
module wms_ctrl
    import wms_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PCW   = 8
) (
    input  logic              step_i,
    input  logic              is_branch_i,
    input  logic              is_jump_i,
    input  logic [LANES-1:0]  cond_i,
    input  logic [PCW-1:0]    target_i,
    input  logic [PCW-1:0]    pc_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [PCW-1:0]    top_reconv_i,
    input  logic [PCW-1:0]    top_else_i,
    input  logic [LANES-1:0]  top_saved_i,
    input  logic [LANES-1:0]  top_emask_i,
    input  path_phase_e       top_phase_i,
    input  logic              empty_i,
    input  logic              full_i,
    output stack_op_e         op_o,
    output logic [PCW-1:0]    pc_next_o,
    output logic [LANES-1:0]  mask_next_o,
    output logic              ovf_set_o
);
    logic [LANES-1:0] taken_lanes;
    logic [LANES-1:0] fallen_lanes;
    logic [PCW-1:0]   pc_seq;
    logic             split;
    logic             then_close;

    assign taken_lanes  = mask_i & cond_i;
    assign fallen_lanes = mask_i & ~cond_i;
    assign pc_seq       = pc_i + 1'b1;
    assign split        = lanes_split(64'(taken_lanes), 64'(fallen_lanes));
    assign then_close   = !empty_i && (top_phase_i == PH_THEN) && is_jump_i
                          && (target_i == top_reconv_i);

    always_comb begin
        op_o        = STK_IDLE;
        pc_next_o   = pc_i;
        mask_next_o = mask_i;
        ovf_set_o   = 1'b0;
        if (step_i) begin
            pc_next_o = pc_seq;
            if (is_branch_i) begin
                if (split) begin
                    if (full_i) begin
                        ovf_set_o = 1'b1;
                    end else begin
                        op_o        = STK_PUSH;
                        mask_next_o = taken_lanes;
                    end
                end else if (taken_lanes == '0) begin
                    pc_next_o = target_i;
                end
            end else if (is_jump_i) begin
                if (then_close) begin
                    if (top_else_i == top_reconv_i) begin
                        op_o        = STK_POP;
                        mask_next_o = top_saved_i;
                        pc_next_o   = top_reconv_i;
                    end else begin
                        op_o        = STK_TOELSE;
                        mask_next_o = top_emask_i;
                        pc_next_o   = top_else_i;
                    end
                end else begin
                    pc_next_o = target_i;
                end
            end
            if (op_o == STK_IDLE && !empty_i && top_phase_i == PH_ELSE
                && pc_next_o == top_reconv_i) begin
                op_o        = STK_POP;
                mask_next_o = top_saved_i;
            end
        end
    end

endmodule

// File: rtl/warp_mask_stack.sv
module warp_mask_stack
    import wms_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int PCW      = 8,
    parameter int DEPTH    = 4,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              is_branch_i,
    input  logic              is_jump_i,
    input  logic [LANES-1:0]  cond_i,
    input  logic [PCW-1:0]    target_i,
    input  logic [PCW-1:0]    reconv_i,
    output logic [PCW-1:0]    pc_o,
    output logic [LANES-1:0]  mask_o,
    output logic [LANES-1:0]  wb_en_o,
    output logic              overflow_o
);
    localparam logic [LANES-1:0] ALL_LANES = '1;
    localparam logic [PCW-1:0]   PC_INIT   = PCW'(RESET_PC);

    logic [PCW-1:0]   pc_q, pc_d;
    logic [LANES-1:0] mask_q, mask_d;
    logic             ovf_q, ovf_set;
    stack_op_e        op_w;

    logic [PCW-1:0]   top_reconv, top_else;
    logic [LANES-1:0] top_saved, top_emask;
    path_phase_e      top_phase;
    logic             stk_empty, stk_full;

    wms_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
        .clk           (clk),
        .rst           (rst),
        .op_i          (op_w),
        .push_reconv_i (reconv_i),
        .push_else_i   (target_i),
        .push_saved_i  (mask_q),
        .push_emask_i  (mask_q & ~cond_i),
        .top_reconv_o  (top_reconv),
        .top_else_o    (top_else),
        .top_saved_o   (top_saved),
        .top_emask_o   (top_emask),
        .top_phase_o   (top_phase),
        .empty_o       (stk_empty),
        .full_o        (stk_full)
    );

    wms_ctrl #(.LANES(LANES), .PCW(PCW)) u_ctrl (
        .step_i       (step_i),
        .is_branch_i  (is_branch_i),
        .is_jump_i    (is_jump_i),
        .cond_i       (cond_i),
        .target_i     (target_i),
        .pc_i         (pc_q),
        .mask_i       (mask_q),
        .top_reconv_i (top_reconv),
        .top_else_i   (top_else),
        .top_saved_i  (top_saved),
        .top_emask_i  (top_emask),
        .top_phase_i  (top_phase),
        .empty_i      (stk_empty),
        .full_i       (stk_full),
        .op_o         (op_w),
        .pc_next_o    (pc_d),
        .mask_next_o  (mask_d),
        .ovf_set_o    (ovf_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= PC_INIT;
            mask_q <= ALL_LANES;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            ovf_q  <= ovf_q | ovf_set;
        end
    end

    assign pc_o       = pc_q;
    assign mask_o     = mask_q;
    assign overflow_o = ovf_q;
    assign wb_en_o    = (step_i && !is_branch_i && !is_jump_i) ? mask_q : '0;

    // R9: overflow flag is sticky until reset
    p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R5: a pop brings back the mask saved with the entry
    p_pop_restore_r5: assert property (@(posedge clk) disable iff (rst)
        (op_w == STK_POP) |=> (mask_q == $past(top_saved)));

    // R3: a push narrows the mask to the condition-true lanes
    p_push_then_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (op_w == STK_PUSH) |=> ((mask_q & ~$past(cond_i)) == '0) && (mask_q != '0));

    // R11: nothing moves while issue is stalled
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pc_q) && $stable(mask_q));

endmodule

// File: tb/warp_mask_stack_tb.sv
module warp_mask_stack_tb;
    localparam int LANES = 8;
    localparam int PCW   = 8;
    localparam int DEPTH = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             step_i = 1'b0;
    logic             is_branch_i = 1'b0;
    logic             is_jump_i = 1'b0;
    logic [LANES-1:0] cond_i = '0;
    logic [PCW-1:0]   target_i = '0;
    logic [PCW-1:0]   reconv_i = '0;
    logic [PCW-1:0]   pc_o;
    logic [LANES-1:0] mask_o;
    logic [LANES-1:0] wb_en_o;
    logic             overflow_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    warp_mask_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .RESET_PC(0)) u_dut (
        .clk(clk), .rst(rst), .step_i(step_i), .is_branch_i(is_branch_i),
        .is_jump_i(is_jump_i), .cond_i(cond_i), .target_i(target_i),
        .reconv_i(reconv_i), .pc_o(pc_o), .mask_o(mask_o), .wb_en_o(wb_en_o),
        .overflow_o(overflow_o)
    );

    typedef struct {
        int        join_pc;
        int        else_pc;
        bit [7:0]  saved;
        bit [7:0]  emask;
        bit        in_else;
    } ref_entry_t;

    ref_entry_t stk[$];
    int       m_pc = 0;
    bit [7:0] m_mask = 8'hFF;
    bit       m_ovf = 0;
    string    tag = "R1";

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // program: kind 0=ALU 1=BR 2=JMP
    task automatic fetch(input int p, output int kind, output bit [7:0] c,
                         output int tgt, output int rc);
        kind = 0; c = 8'h00; tgt = 0; rc = 0;
        case (p)
            1:  begin kind = 1; c = 8'hF0; tgt = 9;  rc = 14; end
            3:  begin kind = 1; c = 8'hCC; tgt = 6;  rc = 8;  end
            5:  begin kind = 2; tgt = 8; end
            8:  begin kind = 2; tgt = 14; end
            10: begin kind = 1; c = 8'hFF; tgt = 12; rc = 13; end
            11: begin kind = 2; tgt = 13; end
            14: begin kind = 1; c = 8'h00; tgt = 16; rc = 17; end
            17: begin kind = 1; c = 8'h0F; tgt = 19; rc = 19; end
            18: begin kind = 2; tgt = 19; end
            19: begin kind = 1; c = 8'hAA; tgt = 30; rc = 31; end
            20: begin kind = 1; c = 8'h88; tgt = 28; rc = 29; end
            21: begin kind = 1; c = 8'h80; tgt = 40; rc = 41; end
            23: begin kind = 2; tgt = 29; end
            29: begin kind = 2; tgt = 31; end
            default: ;
        endcase
    endtask

    task automatic model_step(input bit st, input int kind, input bit [7:0] c,
                              input int tgt, input int rc);
        bit [7:0] t;
        bit [7:0] f;
        bit popped;
        int npc;
        ref_entry_t e;
        popped = 0;
        if (!st) begin
            tag = "R11";
            return;
        end
        t = m_mask & c;
        f = m_mask & ~c;
        npc = m_pc + 1;
        tag = "R2";
        if (kind == 1) begin
            if (t != 0 && f != 0) begin
                if (stk.size() >= DEPTH) begin
                    m_ovf = 1; tag = "R9";
                end else begin
                    e.join_pc = rc; e.else_pc = tgt; e.saved = m_mask; e.emask = f; e.in_else = 0;
                    stk.push_back(e);
                    m_mask = t; tag = "R3";
                    m_pc = npc;
                    return;
                end
            end else if (t == 0) begin
                npc = tgt; tag = "R7";
            end else tag = "R6";
        end else if (kind == 2) begin
            if (stk.size() > 0 && !stk[$].in_else && stk[$].join_pc == tgt) begin
                if (stk[$].else_pc == stk[$].join_pc) begin
                    e = stk.pop_back();
                    m_mask = e.saved; npc = e.join_pc; tag = "R10";
                end else begin
                    stk[$].in_else = 1;
                    m_mask = stk[$].emask; npc = stk[$].else_pc; tag = "R4";
                end
                m_pc = npc;
                return;
            end
            npc = tgt; tag = "R6";
        end
        if (!popped && stk.size() > 0 && stk[$].in_else && stk[$].join_pc == npc) begin
            tag = (stk.size() > 1) ? "R8" : "R5";
            e = stk.pop_back();
            m_mask = e.saved;
        end
        m_pc = npc;
    endtask

    initial begin
        int kind; bit [7:0] c; int tgt; int rc; bit st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc", int'(pc_o), 0);
        check("R1", "mask", int'(mask_o), 8'hFF);
        check("R1", "overflow", int'(overflow_o), 0);
        rst = 1'b0;
        for (int cyc = 0; cyc < 80; cyc++) begin
            if (cyc > 0) begin
                @(negedge clk);
                check(tag, "pc", int'(pc_o), m_pc);
                check(tag, "mask", int'(mask_o), int'(m_mask));
                check(tag, "overflow", int'(overflow_o), int'(m_ovf));
            end
            fetch(m_pc, kind, c, tgt, rc);
            st = (cyc % 7 != 3);
            step_i      = st;
            is_branch_i = (kind == 1);
            is_jump_i   = (kind == 2);
            cond_i      = c;
            target_i    = PCW'(tgt);
            reconv_i    = PCW'(rc);
            #1;
            check(st ? "R2" : "R11", "wb_en", int'(wb_en_o),
                  (st && kind == 0) ? int'(m_mask) : 0);
            model_step(st, kind, c, tgt, rc);
        end
        @(negedge clk);
        check(tag, "pc", int'(pc_o), m_pc);
        check(tag, "mask", int'(mask_o), int'(m_mask));
        check("R9", "overflow", int'(overflow_o), 1);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule